// File: doc/BRIEF.md
# Four-Level Page Table Walker

This block turns a 64-bit virtual address into a physical address. It walks a radix tree of translation tables kept in memory. A request carries the virtual address and the base of the top table. The block first checks the address form. Only the low 48 bits take part in translation, and bits 63 through 48 must all repeat bit 47. An address that breaks this rule is rejected at once, without any memory traffic.

A valid address is resolved by reading one 8-byte entry per level through a single-outstanding request/response memory port. There are four levels, and each table has 512 entries indexed by 9 address bits. The top level is never a leaf. The third and second levels may end the walk early with a 1 GB or 2 MB mapping. The bottom level always maps a 4 KB page.

The result is reported on a one-cycle completion pulse. The pulse carries the physical address, a page-size code, a fault code and the level at which the walk stopped. A surrounding translation unit uses the block to fill misses. It issues one request, waits for the pulse, then issues the next.

Top module: `ptw_walker`

## Requirements
- R1: After reset, `req_ready` is 1, and `mem_req_valid` and `done` are 0.
- R2: An address whose bits 63..48 do not all equal bit 47 is rejected without any memory read. On the cycle after acceptance, `done` rises with fault code 1, level 0, size 0 and PA 0. Both canonical halves are accepted: 0 to 0x00007FFF_FFFFFFFF and 0xFFFF8000_00000000 to 0xFFFFFFFF_FFFFFFFF.
- R3: Index fields are VA[47:39], VA[38:30], VA[29:21] and VA[20:12], for levels 4, 3, 2 and 1. The first read goes to {root[51:12], VA[47:39], 3'b000}, with the low 12 bits of the root ignored. Each later read goes to {entry[51:12], index, 3'b000}, using the entry returned one level above.
- R4: A present entry at level 1 ends the walk with fault 0, size code 0, level 1 and PA = {entry[51:12], VA[11:0]}. Entry bits 63..52 and 11..1 are ignored.
- R5: A present entry at level 3 with bit 7 set is a 1 GB leaf. The walk ends after two reads with size code 2, level 3 and PA = {entry[51:30], VA[29:0]}, ignoring entry bits 29..12.
- R6: A present entry at level 2 with bit 7 set is a 2 MB leaf. The walk ends after three reads with size code 1, level 2 and PA = {entry[51:21], VA[20:0]}.
- R7: Bit 7 has no effect at level 4 (the walk continues to level 3) or at level 1 (the mapping stays 4 KB).
- R8: An entry with bit 0 clear ends the walk at once with fault code 2, the level number (4..1) where it was read, size 0 and PA 0. No further read is made.
- R9: `mem_req_valid` stays high with a stable address until `mem_req_ready`. After the handshake, no new request is raised until `mem_rsp_valid` has returned that entry.
- R10: `req_ready` is high only while no walk is in progress. A `req_valid` seen while it is low is ignored and does not change the running walk's result.
- R11: `done` is a one-cycle pulse. It is raised on the cycle after the response that ends the walk, or on the cycle after acceptance of a rejected address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request strobe |
| req_ready | output | 1 | Walker idle, request accepted when both high |
| req_va | input | 64 | Virtual address to translate |
| req_root | input | 52 | Physical base of the level-4 table (low 12 bits ignored) |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 52 | Byte address of the 8-byte entry |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 64 | Entry returned by memory |
| done | output | 1 | One-cycle completion pulse |
| done_pa | output | 52 | Translated physical address (0 on fault) |
| done_size | output | 2 | 0 = 4 KB, 1 = 2 MB, 2 = 1 GB |
| done_fault | output | 2 | 0 = none, 1 = non-canonical, 2 = not present |
| done_level | output | 3 | Level where the walk ended, 0 for a rejected address |

## Verification
The walker is driven with full four-level chains, with early 2 MB and 1 GB leaves, and with a break of the present bit at each of the four levels. The read count and the stop level then separate the possible end points of a walk. Entries carry set bits in their ignored fields, and bit 7 is set where it must have no effect, so that a wrong field slice or a misplaced leaf test shows up in the PA or size. Addresses just inside and just outside both canonical halves, including back-to-back rejections, separate the form check from the walk. Memory stalls of varying length and stray requests during a walk exercise the handshake and the idle gating.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2
    } walk_st_e;

    typedef enum logic [1:0] {
        FLT_NONE     = 2'd0,
        FLT_NONCANON = 2'd1,
        FLT_NOTPRES  = 2'd2
    } fault_e;

    typedef enum logic [1:0] {
        PG_4K = 2'd0,
        PG_2M = 2'd1,
        PG_1G = 2'd2
    } pgsz_e;

    // entry flag positions
    localparam int unsigned ENT_PRESENT_BIT = 0;
    localparam int unsigned ENT_LEAF_BIT    = 7;

endpackage

// File: rtl/ptw_canon_chk.sv
module ptw_canon_chk #(
    parameter int unsigned VA_W    = 64,
    parameter int unsigned TRANS_W = 48
) (
    input  logic [VA_W-1:0] va,
    output logic            canon_ok
);
    localparam int unsigned EXT_W = VA_W - TRANS_W + 1;

    logic [EXT_W-1:0] ext_bits;

    // the upper bits plus the top translated bit must be all ones or all zeros
    always_comb begin
        ext_bits = va[VA_W-1:TRANS_W-1];
        canon_ok = (&ext_bits) | ~(|ext_bits);
    end

endmodule

// File: rtl/ptw_index_sel.sv
module ptw_index_sel #(
    parameter int unsigned TRANS_W  = 48,
    parameter int unsigned PG_SHIFT = 12,
    parameter int unsigned IDX_W    = 9,
    parameter int unsigned LEVELS   = 4,
    parameter int unsigned LVL_W    = 3
) (
    input  logic [TRANS_W-1:0] va,
    input  logic [LVL_W-1:0]   level,
    output logic [IDX_W-1:0]   idx
);
    logic [IDX_W-1:0] slice [LEVELS];
    logic             unused_low;

    assign unused_low = ^va[PG_SHIFT-1:0];

    for (genvar g = 0; g < LEVELS; g++) begin : g_slice
        assign slice[g] = va[PG_SHIFT + IDX_W*g +: IDX_W];
    end

    always_comb begin
        idx = '0;
        for (int l = 0; l < LEVELS; l++) begin
            if (level == LVL_W'(l + 1)) begin
                idx = slice[l];
            end
        end
    end

endmodule

// File: rtl/ptw_entry_dec.sv
module ptw_entry_dec
    import ptw_pkg::*;
#(
    parameter int unsigned ENTRY_W  = 64,
    parameter int unsigned PA_W     = 52,
    parameter int unsigned TRANS_W  = 48,
    parameter int unsigned PG_SHIFT = 12,
    parameter int unsigned IDX_W    = 9,
    parameter int unsigned LVL_W    = 3,
    parameter int unsigned LEAF_TOP = 3
) (
    input  logic [ENTRY_W-1:0] entry,
    input  logic [LVL_W-1:0]   level,
    input  logic [TRANS_W-1:0] va,
    output logic               present,
    output logic               leaf,
    output logic [PA_W-1:0]    next_base,
    output logic [PA_W-1:0]    leaf_pa,
    output logic [1:0]         leaf_size
);
    logic [PA_W-1:0] off_mask;
    logic [PA_W-1:0] va_ext;
    logic            unused_bits;
    int unsigned     off;

    assign unused_bits = ^{entry[ENTRY_W-1:PA_W], entry[PG_SHIFT-1:ENT_LEAF_BIT+1],
                           entry[ENT_LEAF_BIT-1:ENT_PRESENT_BIT+1]};

    always_comb begin
        present   = entry[ENT_PRESENT_BIT];
        // level 1 always maps; upper levels up to LEAF_TOP map only with the leaf flag
        leaf      = (level == LVL_W'(1)) ||
                    (entry[ENT_LEAF_BIT] && (level > LVL_W'(1)) && (level <= LVL_W'(LEAF_TOP)));
        next_base = {entry[PA_W-1:PG_SHIFT], {PG_SHIFT{1'b0}}};

        off = PG_SHIFT + IDX_W * (int'(level) - 1);
        for (int b = 0; b < PA_W; b++) begin
            off_mask[b] = (b < off);
        end
        va_ext  = PA_W'(va);
        leaf_pa = (entry[PA_W-1:0] & ~off_mask) | (va_ext & off_mask);

        case (level)
            LVL_W'(2): leaf_size = PG_2M;
            LVL_W'(3): leaf_size = PG_1G;
            default:   leaf_size = PG_4K;
        endcase
    end

endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
    import ptw_pkg::*;
#(
    parameter int unsigned VA_W     = 64,
    parameter int unsigned TRANS_W  = 48,
    parameter int unsigned PA_W     = 52,
    parameter int unsigned ENTRY_W  = 64,
    parameter int unsigned LEVELS   = 4,
    parameter int unsigned IDX_W    = 9,
    parameter int unsigned LEAF_TOP = 3,
    parameter int unsigned LVL_W    = $clog2(LEVELS + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [VA_W-1:0]    req_va,
    input  logic [PA_W-1:0]    req_root,
    output logic               mem_req_valid,
    input  logic               mem_req_ready,
    output logic [PA_W-1:0]    mem_req_addr,
    input  logic               mem_rsp_valid,
    input  logic [ENTRY_W-1:0] mem_rsp_data,
    output logic               done,
    output logic [PA_W-1:0]    done_pa,
    output logic [1:0]         done_size,
    output logic [1:0]         done_fault,
    output logic [LVL_W-1:0]   done_level
);
    // entry byte offset bits; a table of 2**IDX_W entries fills one base page
    localparam int unsigned ENT_SH   = $clog2(ENTRY_W / 8);
    localparam int unsigned PG_SHIFT = IDX_W + ENT_SH;

    typedef struct packed {
        walk_st_e           st;
        logic [TRANS_W-1:0] va;
        logic [PA_W-1:0]    base;
        logic [LVL_W-1:0]   level;
        logic               done;
        logic [PA_W-1:0]    pa;
        logic [1:0]         size;
        logic [1:0]         fault;
        logic [LVL_W-1:0]   end_level;
    } walk_t;

    walk_t walk_d, walk_q;

    logic             canon_ok;
    logic [IDX_W-1:0] cur_idx;
    logic             ent_present;
    logic             ent_leaf;
    logic [PA_W-1:0]  ent_next_base;
    logic [PA_W-1:0]  ent_leaf_pa;
    logic [1:0]       ent_leaf_size;

    ptw_canon_chk #(
        .VA_W    (VA_W),
        .TRANS_W (TRANS_W)
    ) u_canon (
        .va       (req_va),
        .canon_ok (canon_ok)
    );

    ptw_index_sel #(
        .TRANS_W  (TRANS_W),
        .PG_SHIFT (PG_SHIFT),
        .IDX_W    (IDX_W),
        .LEVELS   (LEVELS),
        .LVL_W    (LVL_W)
    ) u_idx (
        .va    (walk_q.va),
        .level (walk_q.level),
        .idx   (cur_idx)
    );

    ptw_entry_dec #(
        .ENTRY_W  (ENTRY_W),
        .PA_W     (PA_W),
        .TRANS_W  (TRANS_W),
        .PG_SHIFT (PG_SHIFT),
        .IDX_W    (IDX_W),
        .LVL_W    (LVL_W),
        .LEAF_TOP (LEAF_TOP)
    ) u_dec (
        .entry     (mem_rsp_data),
        .level     (walk_q.level),
        .va        (walk_q.va),
        .present   (ent_present),
        .leaf      (ent_leaf),
        .next_base (ent_next_base),
        .leaf_pa   (ent_leaf_pa),
        .leaf_size (ent_leaf_size)
    );

    always_comb begin
        walk_d      = walk_q;
        walk_d.done = 1'b0;
        unique case (walk_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    walk_d.va = req_va[TRANS_W-1:0];
                    if (canon_ok) begin
                        walk_d.st    = ST_ISSUE;
                        walk_d.base  = {req_root[PA_W-1:PG_SHIFT], {PG_SHIFT{1'b0}}};
                        walk_d.level = LVL_W'(LEVELS);
                    end else begin
                        walk_d.done      = 1'b1;
                        walk_d.pa        = '0;
                        walk_d.size      = PG_4K;
                        walk_d.fault     = FLT_NONCANON;
                        walk_d.end_level = '0;
                    end
                end
            end
            ST_ISSUE: begin
                if (mem_req_ready) begin
                    walk_d.st = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (mem_rsp_valid) begin
                    if (!ent_present) begin
                        walk_d.st        = ST_IDLE;
                        walk_d.done      = 1'b1;
                        walk_d.pa        = '0;
                        walk_d.size      = PG_4K;
                        walk_d.fault     = FLT_NOTPRES;
                        walk_d.end_level = walk_q.level;
                    end else if (ent_leaf) begin
                        walk_d.st        = ST_IDLE;
                        walk_d.done      = 1'b1;
                        walk_d.pa        = ent_leaf_pa;
                        walk_d.size      = ent_leaf_size;
                        walk_d.fault     = FLT_NONE;
                        walk_d.end_level = walk_q.level;
                    end else begin
                        walk_d.st    = ST_ISSUE;
                        walk_d.base  = ent_next_base;
                        walk_d.level = walk_q.level - LVL_W'(1);
                    end
                end
            end
            default: walk_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            walk_q <= '0;
        end else begin
            walk_q <= walk_d;
        end
    end

    assign req_ready     = (walk_q.st == ST_IDLE);
    assign mem_req_valid = (walk_q.st == ST_ISSUE);
    assign mem_req_addr  = {walk_q.base[PA_W-1:PG_SHIFT], cur_idx, {ENT_SH{1'b0}}};
    assign done          = walk_q.done;
    assign done_pa       = walk_q.pa;
    assign done_size     = walk_q.size;
    assign done_fault    = walk_q.fault;
    assign done_level    = walk_q.end_level;

    AST_NONCANON_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !canon_ok) |=>
            (done && done_fault == FLT_NONCANON && !mem_req_valid)) // R2
        else $error("rejected address did not complete at once");

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr))) // R9
        else $error("read request dropped or changed before acceptance");

    AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_ready) |=> !mem_req_valid) // R9
        else $error("second read raised while one is outstanding");

    AST_FAULT_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        (done && done_fault != FLT_NONE) |-> (done_pa == '0 && done_size == PG_4K)) // R8
        else $error("faulted walk reported a mapping");

    AST_LEAF_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (done && done_fault == FLT_NONE) |->
            (done_level == LVL_W'(done_size) + LVL_W'(1))) // R6
        else $error("page size does not match the ending level");

    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !req_ready) // R10
        else $error("walker ready while a read is pending");

endmodule

// File: tb/ptw_walker_bench.sv
`timescale 1ns/1ps
module ptw_walker_bench;

    localparam int PA_W = 52;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [63:0]       req_va = '0;
    logic [PA_W-1:0]   req_root = '0;
    logic              mem_req_valid;
    logic              mem_req_ready;
    logic [PA_W-1:0]   mem_req_addr;
    logic              mem_rsp_valid;
    logic [63:0]       mem_rsp_data;
    logic              done;
    logic [PA_W-1:0]   done_pa;
    logic [1:0]        done_size;
    logic [1:0]        done_fault;
    logic [2:0]        done_level;

    always #10 clk = ~clk;

    ptw_walker u_ptw_walker (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .req_va        (req_va),
        .req_root      (req_root),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_req_addr  (mem_req_addr),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data),
        .done          (done),
        .done_pa       (done_pa),
        .done_size     (done_size),
        .done_fault    (done_fault),
        .done_level    (done_level)
    );

    typedef struct {
        logic [PA_W-1:0] pa;
        logic [1:0]      size;
        logic [1:0]      fault;
        logic [2:0]      level;
        int              reads;
        string           req;
    } exp_t;

    exp_t            sb[$];
    logic [63:0]     mem [logic [PA_W-1:0]];
    logic [PA_W-1:0] addr_log[$];
    int n_checks = 0;
    int n_fail = 0;
    int reads_seen = 0;
    logic rsp_at_edge = 1'b0;
    logic acc_at_edge = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [63:0] ent(input logic [PA_W-1:0] a, input bit ps, input bit p);
        return {12'h000, a[51:12], 4'h0, ps, 6'h00, p};
    endfunction

    function automatic logic [PA_W-1:0] slot(input logic [PA_W-1:0] base, input int lvl,
                                             input logic [63:0] va);
        logic [8:0] idx;
        idx = va[12 + 9*(lvl-1) +: 9];
        return {base[51:12], idx, 3'b000};
    endfunction

    task automatic put(input logic [PA_W-1:0] base, input int lvl, input logic [63:0] va,
                       input logic [63:0] val);
        mem[slot(base, lvl, va)] = val;
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    endtask

    task automatic run(input logic [63:0] va, input logic [PA_W-1:0] root,
                       input logic [PA_W-1:0] pa, input logic [1:0] sz, input logic [1:0] flt,
                       input logic [2:0] lvl, input int rd, input string req, input bit wait_end);
        exp_t e;
        e.pa = pa; e.size = sz; e.fault = flt; e.level = lvl; e.reads = rd; e.req = req;
        sb.push_back(e);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_va    = va;
        req_root  = root;
        @(negedge clk);
        req_valid = 1'b0;
        if (wait_end) begin
            while (sb.size() != 0) @(negedge clk);
        end
    endtask

    always @(posedge clk) begin
        rsp_at_edge <= mem_rsp_valid;
        acc_at_edge <= req_valid && req_ready;
    end

    // memory model with varying stall and latency
    initial begin : responder
        int k;
        logic [PA_W-1:0] a0;
        k = 0;
        mem_req_ready = 1'b0;
        mem_rsp_valid = 1'b0;
        mem_rsp_data  = '0;
        forever begin
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            if (rst_n && mem_req_valid) begin
                a0 = mem_req_addr;
                repeat (k % 3) begin
                    @(negedge clk);
                    chk(mem_req_valid === 1'b1 && mem_req_addr === a0, "R9",
                        "request held", 64'(mem_req_addr), 64'(a0));
                end
                mem_req_ready = 1'b1;
                @(negedge clk);
                mem_req_ready = 1'b0;
                addr_log.push_back(a0);
                repeat ((k / 3) % 2) begin
                    chk(!mem_req_valid, "R9", "read while outstanding", 64'(mem_req_valid), 64'd0);
                    @(negedge clk);
                end
                chk(!mem_req_valid, "R9", "read before response", 64'(mem_req_valid), 64'd0);
                mem_rsp_data  = mem.exists(a0) ? mem[a0] : 64'h0;
                mem_rsp_valid = 1'b1;
                reads_seen++;
                k++;
            end
        end
    end

    // scoreboard monitor
    initial begin : monitor
        exp_t e;
        forever begin
            @(negedge clk);
            if (rst_n && done) begin
                if (sb.size() == 0) begin
                    chk(1'b0, "R10", "unexpected completion", 64'(done_pa), 64'd0);
                end else begin
                    e = sb.pop_front();
                    chk(done_pa === e.pa, e.req, "pa", 64'(done_pa), 64'(e.pa));
                    chk(done_size === e.size, e.req, "size", 64'(done_size), 64'(e.size));
                    chk(done_fault === e.fault, e.req, "fault", 64'(done_fault), 64'(e.fault));
                    chk(done_level === e.level, e.req, "level", 64'(done_level), 64'(e.level));
                    chk(reads_seen == e.reads, e.req, "read count", 64'(reads_seen), 64'(e.reads));
                    chk(rsp_at_edge || acc_at_edge, "R11", "done timing", 64'(rsp_at_edge), 64'd1);
                end
                reads_seen = 0;
            end
        end
    end

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: run did not finish");
        summary();
        $finish;
    end

    initial begin : main
        logic [63:0]     va;
        logic [PA_W-1:0] rt, t3, t2, t1, pg;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready === 1'b1, "R1", "req_ready after reset", 64'(req_ready), 64'd1);
        chk(mem_req_valid === 1'b0, "R1", "mem_req_valid after reset", 64'(mem_req_valid), 64'd0);
        chk(done === 1'b0, "R1", "done after reset", 64'(done), 64'd0);

        // R3 R4 R7: full 4 KB walk, junk in ignored bits, bit 7 set at level 1
        va = 64'h0000_1234_5678_9ABC;
        rt = 52'h0_0000_0010_0000; t3 = 52'h0_0000_0020_0000;
        t2 = 52'h0_0000_0030_0000; t1 = 52'h0_0000_0040_0000; pg = 52'h0_00AB_CDEF_1000;
        put(rt, 4, va, ent(t3, 1'b0, 1'b1));
        put(t3, 3, va, ent(t2, 1'b0, 1'b1));
        put(t2, 2, va, ent(t1, 1'b0, 1'b1));
        put(t1, 1, va, ent(pg, 1'b0, 1'b1) | 64'hFFF0_0000_0000_0FFE);
        addr_log.delete();
        run(va, rt | 52'hABC, {pg[51:12], va[11:0]}, 2'd0, 2'd0, 3'd1, 4, "R4", 1'b1);
        chk(addr_log.size() == 4, "R3", "address count", 64'(addr_log.size()), 64'd4);
        if (addr_log.size() == 4) begin
            chk(addr_log[0] == slot(rt, 4, va), "R3", "L4 addr", 64'(addr_log[0]), 64'(slot(rt, 4, va)));
            chk(addr_log[1] == slot(t3, 3, va), "R3", "L3 addr", 64'(addr_log[1]), 64'(slot(t3, 3, va)));
            chk(addr_log[2] == slot(t2, 2, va), "R3", "L2 addr", 64'(addr_log[2]), 64'(slot(t2, 2, va)));
            chk(addr_log[3] == slot(t1, 1, va), "R3", "L1 addr", 64'(addr_log[3]), 64'(slot(t1, 1, va)));
        end

        // R6: 2 MB leaf in the upper canonical half
        va = 64'hFFFF_8765_4321_0FED;
        rt = 52'h0_0000_0100_0000; t3 = 52'h0_0000_0100_1000; t2 = 52'h0_0000_0100_2000;
        pg = 52'h0_0000_7FE0_0000;
        put(rt, 4, va, ent(t3, 1'b0, 1'b1));
        put(t3, 3, va, ent(t2, 1'b0, 1'b1));
        put(t2, 2, va, ent(pg, 1'b1, 1'b1));
        run(va, rt, {pg[51:21], va[20:0]}, 2'd1, 2'd0, 3'd2, 3, "R6", 1'b1);

        // R5: 1 GB leaf, entry bits 29..12 set and ignored
        va = 64'h0000_7ABC_DEF0_1234;
        rt = 52'h0_0000_0200_0000; t3 = 52'h0_0000_0200_1000; pg = 52'h0_0123_C000_0000;
        put(rt, 4, va, ent(t3, 1'b0, 1'b1));
        put(t3, 3, va, ent(pg, 1'b1, 1'b1) | 64'h0000_0000_3FFF_F000);
        run(va, rt, {pg[51:30], va[29:0]}, 2'd2, 2'd0, 3'd3, 2, "R5", 1'b1);

        // R7: bit 7 at level 4 does not end the walk
        va = 64'h0000_0000_0040_3008;
        rt = 52'h0_0000_0300_0000; t3 = 52'h0_0000_0300_1000;
        t2 = 52'h0_0000_0300_2000; t1 = 52'h0_0000_0300_3000; pg = 52'h0_0000_9999_9000;
        put(rt, 4, va, ent(t3, 1'b1, 1'b1));
        put(t3, 3, va, ent(t2, 1'b0, 1'b1));
        put(t2, 2, va, ent(t1, 1'b0, 1'b1));
        put(t1, 1, va, ent(pg, 1'b1, 1'b1));
        run(va, rt, {pg[51:12], va[11:0]}, 2'd0, 2'd0, 3'd1, 4, "R7", 1'b1);

        // R8: not present at each level
        va = 64'h0000_0100_0000_0000;
        run(va, 52'h0_0000_0400_0000, '0, 2'd0, 2'd2, 3'd4, 1, "R8", 1'b1);
        rt = 52'h0_0000_0500_0000;
        put(rt, 4, va, ent(52'h0_0000_0500_1000, 1'b0, 1'b1));
        run(va, rt, '0, 2'd0, 2'd2, 3'd3, 2, "R8", 1'b1);
        rt = 52'h0_0000_0600_0000;
        put(rt, 4, va, ent(52'h0_0000_0600_1000, 1'b0, 1'b1));
        put(52'h0_0000_0600_1000, 3, va, ent(52'h0_0000_0600_2000, 1'b0, 1'b1));
        put(52'h0_0000_0600_2000, 2, va, ent(52'h0_0000_0600_3000, 1'b1, 1'b0));
        run(va, rt, '0, 2'd0, 2'd2, 3'd2, 3, "R8", 1'b1);
        rt = 52'h0_0000_0700_0000;
        put(rt, 4, va, ent(52'h0_0000_0700_1000, 1'b0, 1'b1));
        put(52'h0_0000_0700_1000, 3, va, ent(52'h0_0000_0700_2000, 1'b0, 1'b1));
        put(52'h0_0000_0700_2000, 2, va, ent(52'h0_0000_0700_3000, 1'b0, 1'b1));
        put(52'h0_0000_0700_3000, 1, va, 64'hFFFF_FFFF_FFFF_FFFE);
        run(va, rt, '0, 2'd0, 2'd2, 3'd1, 4, "R8", 1'b1);

        // R2: non-canonical addresses, last two back to back
        run(64'h0000_8000_0000_0000, 52'h0_0000_0010_0000, '0, 2'd0, 2'd1, 3'd0, 0, "R2", 1'b1);
        run(64'hFFFF_7FFF_FFFF_FFFF, 52'h0_0000_0010_0000, '0, 2'd0, 2'd1, 3'd0, 0, "R2", 1'b1);
        run(64'h8000_0000_0000_0000, 52'h0_0000_0010_0000, '0, 2'd0, 2'd1, 3'd0, 0, "R2", 1'b0);
        run(64'h0001_0000_0000_0000, 52'h0_0000_0010_0000, '0, 2'd0, 2'd1, 3'd0, 0, "R2", 1'b1);
        // R2: canonical edges walk into an empty table
        run(64'h0000_7FFF_FFFF_FFFF, 52'h0_0000_0800_0000, '0, 2'd0, 2'd2, 3'd4, 1, "R2", 1'b1);
        run(64'hFFFF_8000_0000_0000, 52'h0_0000_0900_0000, '0, 2'd0, 2'd2, 3'd4, 1, "R2", 1'b1);

        // R10: stray requests during a walk are ignored
        va = 64'h0000_1234_5678_9ABC;
        run(va, 52'h0_0000_0010_0000, 52'h0_00AB_CDEF_1ABC, 2'd0, 2'd0, 3'd1, 4, "R10", 1'b0);
        repeat (6) begin
            if (!req_ready) begin
                req_valid = 1'b1;
                req_va    = 64'h8000_0000_0000_0000;
                req_root  = 52'h0_0000_0900_0000;
            end else begin
                req_valid = 1'b0;
            end
            @(negedge clk);
        end
        req_valid = 1'b0;
        while (sb.size() != 0) @(negedge clk);
        repeat (4) @(negedge clk);
        chk(done === 1'b0, "R11", "no extra completion", 64'(done), 64'd0);

        summary();
        $finish;
    end

endmodule